// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Pool

This block holds a small pool of reservation stations and a register status table. Together they let operations issued in program order start execution out of order. Each operation names two source registers and one destination register.

At issue the operation takes the lowest free station. Each source register either supplies its value at once or supplies the tag of the station that will produce it. The destination register's status entry is then pointed at the new station. Waiting stations watch a shared result bus, which carries a value together with the tag of the station that produced it. When a tag matches, the station takes the value in that same cycle.

A station whose operands are both present is offered to a functional unit port. The architectural register file is written from the result bus only by the newest pending writer. Renaming through the status table therefore removes write-after-read and write-after-write hazards. The functional unit sits outside the block: it accepts dispatched operations and later drives the result bus with the tag it was given.

Top module: `tag_rs_pool`

## Requirements
- R1: After reset every station is free and nothing is offered for dispatch. No register has a pending producer, and register k holds the value k.
- R2: A station's tag is its index plus one (1 to NRS); tag 0 means "no producer". An accepted issue occupies the lowest-numbered free station.
- R3: At issue, a source register whose status tag is 0 gives its value to the station. Otherwise the register's status tag is recorded, and the station waits.
- R4: If an issue coincides with a broadcast of a source register's producer tag, the station takes the broadcast value directly.
- R5: On a valid broadcast, every busy station waiting on that tag, in either operand, takes the value at that clock edge and stops waiting.
- R6: A station is offered (disp_valid, disp_tag, disp_op, disp_vj, disp_vk) when it is busy, has both operands and has not been dispatched yet. The lowest-numbered such station is offered. The offer is accepted when fu_ready is high, and that station is never offered again.
- R7: A station becomes free at the edge where its own tag is broadcast, and it can be reused from the next cycle.
- R8: iss_stall is high exactly when every station is busy. An issue request made while stalled has no effect on stations or register status.
- R9: An issue sets the destination register's status tag to the new station's tag, replacing any older one. A broadcast writes a register only if the register's status tag equals the broadcast tag, and then clears that tag. A broadcast from an older writer leaves both the register and its tag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Operation code carried to the unit |
| iss_src1 | input | log2(NREG) | First source register |
| iss_src2 | input | log2(NREG) | Second source register |
| iss_dst | input | log2(NREG) | Destination register |
| iss_stall | output | 1 | No station free; issue not accepted |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | log2(NRS+1) | Tag of the producing station |
| cdb_data | input | DW | Result value |
| fu_ready | input | 1 | Functional unit accepts the offered station |
| disp_valid | output | 1 | A ready station is offered |
| disp_tag | output | log2(NRS+1) | Tag of the offered station |
| disp_op | output | OPW | Operation of the offered station |
| disp_vj | output | DW | First operand value |
| disp_vk | output | DW | Second operand value |

## Verification
The bench builds the pool with NRS=3, NREG=8, DW=16 and OPW=4. With only three stations, a few issues are enough to fill the pool, so the stall, the ignored issue while stalled, and the release of a station on its own broadcast can all be reached in a handful of cycles. The same setting puts three stations in the ready state together, which exercises the lowest-index dispatch order. Eight registers, each reset to its own index, let every copied operand show which register it came from. This also makes the newer and older writers of a single register easy to tell apart.

// File: rtl/tag_rs_pool.sv
module tag_rs_pool #(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int OPW  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [OPW-1:0]            iss_op,
  input  logic [$clog2(NREG)-1:0]   iss_src1,
  input  logic [$clog2(NREG)-1:0]   iss_src2,
  input  logic [$clog2(NREG)-1:0]   iss_dst,
  output logic                      iss_stall,
  input  logic                      cdb_valid,
  input  logic [$clog2(NRS+1)-1:0]  cdb_tag,
  input  logic [DW-1:0]             cdb_data,
  input  logic                      fu_ready,
  output logic                      disp_valid,
  output logic [$clog2(NRS+1)-1:0]  disp_tag,
  output logic [OPW-1:0]            disp_op,
  output logic [DW-1:0]             disp_vj,
  output logic [DW-1:0]             disp_vk
);
  localparam int TW = $clog2(NRS+1);
  localparam int RW = $clog2(NREG);
  localparam int SW = (NRS > 1) ? $clog2(NRS) : 1;

  logic [NRS-1:0] busy, started, ready;
  logic [OPW-1:0] op_q [NRS];
  logic [DW-1:0]  vj_q [NRS];
  logic [DW-1:0]  vk_q [NRS];
  logic [TW-1:0]  qj_q [NRS];
  logic [TW-1:0]  qk_q [NRS];

  logic [DW-1:0]  rval  [NREG];
  logic [TW-1:0]  rstat [NREG];

  logic          free_hit;
  logic [SW-1:0] free_idx, disp_idx;
  logic [TW-1:0] new_tag;
  logic          issue_fire, disp_fire;

  logic [DW-1:0] s1_v, s2_v;
  logic [TW-1:0] s1_q, s2_q;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = NRS-1; i >= 0; i--)
      if (!busy[i]) begin
        free_hit = 1'b1;
        free_idx = SW'(i);
      end
  end

  assign iss_stall  = !free_hit;
  assign issue_fire = iss_valid && free_hit;
  assign new_tag    = TW'(free_idx) + TW'(1);

  always_comb begin
    s1_q = rstat[iss_src1];
    s1_v = '0;
    if (s1_q == '0) s1_v = rval[iss_src1];
    else if (cdb_valid && cdb_tag == s1_q) begin
      s1_v = cdb_data;
      s1_q = '0;
    end
    s2_q = rstat[iss_src2];
    s2_v = '0;
    if (s2_q == '0) s2_v = rval[iss_src2];
    else if (cdb_valid && cdb_tag == s2_q) begin
      s2_v = cdb_data;
      s2_q = '0;
    end
  end

  always_comb
    for (int i = 0; i < NRS; i++)
      ready[i] = busy[i] && !started[i] && qj_q[i] == '0 && qk_q[i] == '0;

  always_comb begin
    disp_idx = '0;
    for (int i = NRS-1; i >= 0; i--)
      if (ready[i]) disp_idx = SW'(i);
  end

  assign disp_valid = |ready;
  assign disp_fire  = disp_valid && fu_ready;
  assign disp_tag   = TW'(disp_idx) + TW'(1);
  assign disp_op    = op_q[disp_idx];
  assign disp_vj    = vj_q[disp_idx];
  assign disp_vk    = vk_q[disp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      started <= '0;
      for (int i = 0; i < NRS; i++) begin
        op_q[i] <= '0;
        vj_q[i] <= '0;
        vk_q[i] <= '0;
        qj_q[i] <= '0;
        qk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (issue_fire && free_idx == SW'(i)) begin
          busy[i]    <= 1'b1;
          started[i] <= 1'b0;
          op_q[i]    <= iss_op;
          vj_q[i]    <= s1_v;
          vk_q[i]    <= s2_v;
          qj_q[i]    <= s1_q;
          qk_q[i]    <= s2_q;
        end else begin
          if (disp_fire && disp_idx == SW'(i)) started[i] <= 1'b1;
          if (cdb_valid && cdb_tag == TW'(i+1)) begin
            busy[i]    <= 1'b0;
            started[i] <= 1'b0;
          end
          if (busy[i] && cdb_valid && qj_q[i] != '0 && qj_q[i] == cdb_tag) begin
            vj_q[i] <= cdb_data;
            qj_q[i] <= '0;
          end
          if (busy[i] && cdb_valid && qk_q[i] != '0 && qk_q[i] == cdb_tag) begin
            vk_q[i] <= cdb_data;
            qk_q[i] <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        rval[r]  <= DW'(r);
        rstat[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++)
        if (cdb_valid && rstat[r] != '0 && rstat[r] == cdb_tag) begin
          rval[r]  <= cdb_data;
          rstat[r] <= '0;
        end
      if (issue_fire) rstat[iss_dst] <= new_tag;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall && !cdb_valid |=> busy == $past(busy));

  // R2
  alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> busy[$past(free_idx)]);

  // R6
  no_double_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> !(disp_valid && disp_tag == $past(disp_tag)));

  genvar g;
  generate
    for (g = 0; g < NRS; g++) begin : g_st_chk
      // R5
      capture_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[g] && cdb_valid && qj_q[g] != '0 && qj_q[g] == cdb_tag && !(issue_fire && free_idx == SW'(g))
        |=> qj_q[g] == '0 && vj_q[g] == $past(cdb_data));
      // R7
      release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid && cdb_tag == TW'(g+1) && busy[g] |=> !busy[g]);
    end
    for (g = 0; g < NREG; g++) begin : g_reg_chk
      // R9
      reg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid && rstat[g] != '0 && rstat[g] == cdb_tag && !(issue_fire && iss_dst == RW'(g))
        |=> rstat[g] == '0 && rval[g] == $past(cdb_data));
      // R9
      stat_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rstat[g] != '0 |-> busy[SW'(rstat[g] - TW'(1))]);
    end
  endgenerate
endmodule

// File: tb/tag_rs_pool_bench.sv
module tag_rs_pool_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRS  = 3;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int OPW  = 4;
  localparam int TW   = $clog2(NRS+1);
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [OPW-1:0] iss_op = '0;
  logic [RW-1:0] iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
  logic iss_stall;
  logic cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic fu_ready = 1'b0;
  logic disp_valid;
  logic [TW-1:0] disp_tag;
  logic [OPW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_rs_pool #(.NRS(NRS), .NREG(NREG), .DW(DW), .OPW(OPW)) u_tag_rs_pool (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_src1(iss_src1),
    .iss_src2(iss_src2), .iss_dst(iss_dst), .iss_stall(iss_stall),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic iv, input int op, input int a, input int b, input int d,
                      input logic cv, input int ct, input int cd, input logic fr);
    iss_valid = iv;
    iss_op    = OPW'(op);
    iss_src1  = RW'(a);
    iss_src2  = RW'(b);
    iss_dst   = RW'(d);
    cdb_valid = cv;
    cdb_tag   = TW'(ct);
    cdb_data  = DW'(cd);
    fu_ready  = fr;
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0;
    cdb_valid = 1'b0;
    fu_ready  = 1'b0;
  endtask

  task automatic issue(input int op, input int a, input int b, input int d);
    step(1'b1, op, a, b, d, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic bcast(input int t, input int v);
    step(1'b0, 0, 0, 0, 0, 1'b1, t, v, 1'b0);
  endtask

  task automatic accept();
    step(1'b0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 stall after reset", int'(iss_stall), 0);
    chk("R1 no offer after reset", int'(disp_valid), 0);
  endtask

  task automatic t_basic();
    issue(5, 2, 3, 4);
    chk("R2 offer", int'(disp_valid), 1);
    chk("R2 first tag", int'(disp_tag), 1);
    chk("R6 op carried", int'(disp_op), 5);
    chk("R1 R3 vj from reg2", int'(disp_vj), 2);
    chk("R3 vk from reg3", int'(disp_vk), 3);
    accept();
    chk("R6 not offered twice", int'(disp_valid), 0);
    bcast(1, 100);
    issue(1, 4, 4, 6);
    chk("R7 station 1 reused", int'(disp_tag), 1);
    chk("R9 reg4 written", int'(disp_vj), 100);
    chk("R9 reg4 both operands", int'(disp_vk), 100);
    accept();
    bcast(1, 7);
  endtask

  task automatic t_capture();
    issue(2, 6, 1, 7);
    issue(3, 7, 0, 2);
    chk("R6 lowest offered", int'(disp_tag), 1);
    chk("R3 reg6 value", int'(disp_vj), 7);
    accept();
    chk("R3 waiting station not offered", int'(disp_valid), 0);
    bcast(1, 50);
    chk("R5 capture makes ready", int'(disp_valid), 1);
    chk("R5 tag", int'(disp_tag), 2);
    chk("R5 captured value", int'(disp_vj), 50);
    chk("R5 other operand", int'(disp_vk), 0);
    accept();
    bcast(2, 9);
  endtask

  task automatic t_forward();
    issue(4, 2, 2, 3);
    chk("R9 reg2 from bus", int'(disp_vj), 9);
    accept();
    step(1'b1, 5, 3, 5, 1, 1'b1, 1, 33, 1'b0);
    chk("R4 tag", int'(disp_tag), 2);
    chk("R4 forwarded value", int'(disp_vj), 33);
    chk("R4 plain value", int'(disp_vk), 5);
    accept();
    bcast(2, 1);
    issue(6, 3, 3, 0);
    chk("R9 reg3 written at forward", int'(disp_vj), 33);
    accept();
    bcast(1, 0);
  endtask

  task automatic t_waw();
    issue(1, 0, 0, 5);
    issue(2, 1, 1, 5);
    accept();
    accept();
    issue(3, 5, 0, 0);
    bcast(1, 11);
    chk("R9 older writer ignored, reader still waits", int'(disp_valid), 0);
    bcast(2, 22);
    chk("R5 R9 reader ready", int'(disp_valid), 1);
    chk("R9 reader tag", int'(disp_tag), 3);
    chk("R9 newest value", int'(disp_vj), 22);
    accept();
    bcast(3, 0);
    issue(4, 5, 5, 6);
    chk("R9 reg5 holds newest", int'(disp_vj), 22);
    accept();
    bcast(1, 0);
  endtask

  task automatic t_stall();
    issue(1, 1, 1, 2);
    issue(2, 1, 1, 3);
    chk("R8 not yet full", int'(iss_stall), 0);
    issue(3, 1, 1, 4);
    chk("R8 full", int'(iss_stall), 1);
    issue(7, 0, 0, 0);
    chk("R8 still full", int'(iss_stall), 1);
    chk("R6 priority 1", int'(disp_tag), 1);
    accept();
    chk("R6 priority 2", int'(disp_tag), 2);
    accept();
    chk("R6 priority 3", int'(disp_tag), 3);
    accept();
    chk("R6 all sent", int'(disp_valid), 0);
    chk("R7 busy until broadcast", int'(iss_stall), 1);
    bcast(2, 5);
    chk("R7 freed by broadcast", int'(iss_stall), 0);
    bcast(1, 5);
    bcast(3, 5);
    issue(6, 0, 0, 1);
    chk("R8 ignored issue left reg0 free", int'(disp_valid), 1);
    chk("R8 tag", int'(disp_tag), 1);
    chk("R8 op", int'(disp_op), 6);
    chk("R8 reg0 value", int'(disp_vj), 0);
    accept();
    bcast(1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_capture();
    t_forward();
    t_waw();
    t_stall();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule